// File: doc/BRIEF.md
# Dual-Channel Serial DAC Code Loader

The block takes a serial stream that carries two DAC codes in one 24-bit word. It holds them in two 12-bit code registers, one for channel A and one for channel B. A host selects the block with an active-low select line and clocks data in, most significant bit first. The host sends channel B's code first and channel A's code second. The bit that arrives last lands at the top of the shift chain. Each half of the chain holds its code with the MSB at the lower index, so the loader bit-reverses each half on transfer.

Two active-low strobes copy the current chain contents into channel A, channel B, or both in the same cycle. An active-low clear empties the chain and both code registers at once, without waiting for a clock edge. All serial inputs are asynchronous to the system clock. They pass through two-flop synchronizers, and a falling serial-clock edge is detected from the synchronized history. The block drives the two code values to the analog converters, which are outside it.

Top module: `dual_dac_loader`

## Requirements
- R1: While rst_ni is low, code_a_o, code_b_o and the shift chain are all zero, without waiting for a clock edge. After release, a transfer with no new shifts delivers zero.
- R2: The chain advances by one bit only on a falling edge of sclk_i. Changes on sdata_i while sclk_i is static, and rising edges of sclk_i, do not shift it.
- R3: Each shifted bit enters chain position 23 and older bits move toward position 0. After 24 shifts the first 12 bits sent form channel B's code and the last 12 bits form channel A's code, each MSB first.
- R4: With cs_ni low, upd_a_ni low and upd_b_ni high, code_a_o takes chain positions 23..12, with position 12 as bit 11 and position 23 as bit 0. code_b_o is unchanged.
- R5: With cs_ni low, upd_b_ni low and upd_a_ni high, code_b_o takes chain positions 11..0, with position 0 as bit 11 and position 11 as bit 0. code_a_o is unchanged.
- R6: With cs_ni low and both strobes low, both code registers load from their halves in the same cycle.
- R7: With cs_ni high, falling sclk_i edges do not shift and the strobes do not transfer. Both outputs and the chain contents stay as they were.
- R8: A strobe held low reloads its register every system cycle. While the strobe stays low, the output follows new shifts, and a shift and transfer in the same cycle use the pre-shift chain.
- R9: When more than 24 bits are sent, only the last 24 remain. Older bits drop out at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample all serial inputs |
| rst_ni | input | 1 | Active-low asynchronous clear; release is synchronized |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first, channel B code first |
| cs_ni | input | 1 | Active-low select; high blocks shifting and transfers |
| upd_a_ni | input | 1 | Active-low transfer strobe for channel A |
| upd_b_ni | input | 1 | Active-low transfer strobe for channel B |
| code_a_o | output | 12 | Channel A code register |
| code_b_o | output | 12 | Channel B code register |

## Verification
The hardest case to reach is a transfer strobe that stays low while new bits are still shifting in. The output must then follow the chain cycle by cycle instead of holding a snapshot. The bench holds upd_a_ni low across twelve further falling sclk_i edges and compares code_a_o with the newly sent code before it releases the strobe. The bench also sends a word with cs_ni high and then transfers with cs_ni low. This shows through the outputs that the chain kept its earlier contents.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    XFER_NONE = 2'b00,
    XFER_A    = 2'b01,
    XFER_B    = 2'b10,
    XFER_AB   = 2'b11
  } xfer_e;

  function automatic xfer_e decode_xfer(input logic cs_n, input logic upd_a_n,
                                        input logic upd_b_n);
    if (cs_n) return XFER_NONE;
    unique case ({!upd_b_n, !upd_a_n})
      2'b01:   return XFER_A;
      2'b10:   return XFER_B;
      2'b11:   return XFER_AB;
      default: return XFER_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dd_rst_sync.sv
module dd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/dd_sync.sv
module dd_sync #(
  parameter int unsigned        WIDTH  = 1,
  parameter int unsigned        STAGES = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dd_shift_chain.sv
module dd_shift_chain #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  // newest bit at the top, older bits drift toward index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_q <= '0;
    else if (shift_en_i) word_q <= {bit_i, word_q[WORD_W-1:1]};
  end

  assign word_o = word_q;

  assert_chain_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(word_q));

  assert_newest_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (word_q[WORD_W-1] == $past(bit_i))
                   && (word_q[0] == $past(word_q[1])));
endmodule

// File: rtl/dd_code_reg.sv
module dd_code_reg #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned WORD_W = 24,
  parameter int unsigned BASE   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] src_rev;
  logic [CODE_W-1:0] code_q;

  // lower chain index carries the MSB
  for (genvar i = 0; i < CODE_W; i++) begin : g_rev
    assign src_rev[CODE_W-1-i] = word_i[BASE+i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= '0;
    else if (load_i) code_q <= src_rev;
  end

  assign code_o = code_q;

  // unstrobed channel keeps its code (R4, R5)
  assert_code_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_q));

  assert_msb_map_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (code_q[CODE_W-1] == $past(word_i[BASE]))
               && (code_q[0] == $past(word_i[BASE+CODE_W-1])));
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dual_dac_pkg::*;
#(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              cs_ni,
  input  logic              upd_a_ni,
  input  logic              upd_b_ni,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o
);
  localparam int unsigned WORD_W = CODE_W * NUM_CH;
  localparam int unsigned IN_W   = 5;

  logic              rst_n;
  logic [IN_W-1:0]   raw_in, syn_in;
  logic              sclk_s, sdata_s, cs_s, upd_a_s, upd_b_s;
  logic              sclk_prev_q;
  logic              sclk_fall, shift_en;
  xfer_e             xfer;
  logic [NUM_CH-1:0] load_en;
  logic [WORD_W-1:0] word;
  logic [CODE_W-1:0] code [NUM_CH];

  dd_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  assign raw_in = {sclk_i, sdata_i, cs_ni, upd_a_ni, upd_b_ni};

  // idle levels: clock high, select and strobes inactive
  dd_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b10111)) i_in_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign {sclk_s, sdata_s, cs_s, upd_a_s, upd_b_s} = syn_in;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b1;
    else        sclk_prev_q <= sclk_s;
  end

  assign sclk_fall = sclk_prev_q && !sclk_s;
  assign shift_en  = sclk_fall && !cs_s;
  assign xfer      = decode_xfer(cs_s, upd_a_s, upd_b_s);
  assign load_en[0] = (xfer == XFER_A) || (xfer == XFER_AB);
  assign load_en[1] = (xfer == XFER_B) || (xfer == XFER_AB);

  dd_shift_chain #(.WORD_W(WORD_W)) i_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .shift_en_i(shift_en),
    .bit_i     (sdata_s),
    .word_o    (word)
  );

  // channel 0 (A) takes the upper half, channel 1 (B) the lower
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dd_code_reg #(
      .CODE_W(CODE_W),
      .WORD_W(WORD_W),
      .BASE  ((NUM_CH - 1 - c) * CODE_W)
    ) i_code (
      .clk_i (clk_i),
      .rst_ni(rst_n),
      .load_i(load_en[c]),
      .word_i(word),
      .code_o(code[c])
    );
  end

  assign code_a_o = code[0];
  assign code_b_o = code[1];

  assert_deselect_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    cs_s |=> $stable(code_a_o) && $stable(code_b_o) && $stable(word));

  assert_joint_load_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!cs_s && !upd_a_s && !upd_b_s)
      |=> (code_a_o[CODE_W-1] == $past(word[CODE_W]))
          && (code_b_o[CODE_W-1] == $past(word[0])));

  assert_no_rise_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!sclk_prev_q && sclk_s) |=> $stable(word));
endmodule

// File: tb/test_dual_dac_loader.sv
module test_dual_dac_loader;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b1, sdata = 1'b0, cs_n = 1'b1, upd_a_n = 1'b1, upd_b_n = 1'b1;
  logic [W-1:0] code_a, code_b;
  logic [W-1:0] exp_a, exp_b;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_loader i_dual_dac_loader (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk),
    .sdata_i (sdata),
    .cs_ni   (cs_n),
    .upd_a_ni(upd_a_n),
    .upd_b_ni(upd_b_n),
    .code_a_o(code_a),
    .code_b_o(code_b)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdata = b;   tick(4);
    sclk = 1'b0; tick(4);
    sclk = 1'b1; tick(4);
  endtask

  task automatic send_code(input logic [W-1:0] v);
    for (int i = W-1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic strobe(input bit a, input bit b);
    upd_a_n = !a; upd_b_n = !b; tick(5);
    upd_a_n = 1'b1; upd_b_n = 1'b1; tick(5);
  endtask

  initial begin
    tick(3);
    check("R1 reset a", code_a, '0);
    check("R1 reset b", code_b, '0);
    rst_ni = 1'b1; tick(5);
    exp_a = '0; exp_b = '0;
    cs_n = 1'b0; tick(3);

    // walking ones and arithmetic patterns, rotating transfer modes
    for (int k = 0; k < 28; k++) begin
      logic [W-1:0] a, b;
      int mode;
      if (k < W) begin
        b = 12'(1 << k);
        a = 12'(12'h800 >> k);
      end else begin
        a = 12'((k * 683 + 291) % 4096);
        b = 12'((k * 1571 + 3000) % 4096);
      end
      mode = k % 3;
      send_code(b);
      send_code(a);
      strobe(mode != 1, mode != 0);
      if (mode != 1) exp_a = a;
      if (mode != 0) exp_b = b;
      if (mode == 0) begin
        check("R4 load a", code_a, exp_a); check("R4 b kept", code_b, exp_b);
      end else if (mode == 1) begin
        check("R5 load b", code_b, exp_b); check("R5 a kept", code_a, exp_a);
      end else begin
        check("R6 both a", code_a, exp_a); check("R6 both b", code_b, exp_b);
      end
      if (k < W) check("R3 bit order a", code_a, mode != 1 ? a : exp_a);
    end

    // R9: 36 bits sent, only the last 24 survive
    send_code(12'hFFF); send_code(12'h5A3); send_code(12'h0C7);
    strobe(1, 1);
    check("R9 overflow a", code_a, 12'h0C7);
    check("R9 overflow b", code_b, 12'h5A3);

    // R2: data toggling with sclk static, then a lone rising edge
    for (int i = 0; i < 6; i++) begin sdata = ~sdata; tick(4); end
    cs_n = 1'b1; tick(4); sclk = 1'b0; tick(4); cs_n = 1'b0; tick(4);
    sclk = 1'b1; tick(4);
    strobe(1, 1);
    check("R2 no shift a", code_a, 12'h0C7);
    check("R2 no shift b", code_b, 12'h5A3);

    // R7: deselected word and strobes are ignored
    cs_n = 1'b1; tick(3);
    send_code(12'h111); send_code(12'h222);
    strobe(1, 1);
    check("R7 strobe ignored a", code_a, 12'h0C7);
    check("R7 strobe ignored b", code_b, 12'h5A3);
    cs_n = 1'b0; tick(3);
    strobe(1, 1);
    check("R7 chain kept a", code_a, 12'h0C7);
    check("R7 chain kept b", code_b, 12'h5A3);

    // R8: held strobe follows ongoing shifts
    upd_a_n = 1'b0; tick(5);
    send_code(12'h9E4);
    tick(2);
    check("R8 follow a", code_a, 12'h9E4);
    send_bit(1'b1);
    check("R8 follow shifted a", code_a, 12'h3C9);
    upd_a_n = 1'b1; tick(5);
    check("R8 b untouched", code_b, 12'h5A3);

    // R1: asynchronous clear, then empty chain
    rst_ni = 1'b0; #1;
    check("R1 async a", code_a, '0);
    check("R1 async b", code_b, '0);
    tick(3); rst_ni = 1'b1; tick(5);
    strobe(1, 1);
    check("R1 chain cleared a", code_a, '0);
    check("R1 chain cleared b", code_b, '0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule